// File: doc/BRIEF.md
# Truth-Table Bitwise Logic Unit

This block applies one two-input Boolean function to every bit position of two operand words at once. The function is not selected by an opcode. A 4-bit truth table is supplied directly, and every bit slice looks up its own answer in that table. Each slice is a 4-to-1 multiplexer. The truth-table bits are its data inputs, and the two operand bits of that position form its select index.

The unit is purely combinational. A result follows its inputs in the same cycle, so it fits inside an arithmetic datapath between operand registers and a result register. Any of the sixteen two-input functions can be produced. The datapath drives the four codes for AND, OR, XOR and pass-through of the first operand.

Top module: `bitwise_logic_unit`

## Requirements
- R1: For every bit position i, result[i] equals func_table[k], where k = 2*operand_b[i] + operand_a[i]. The table index uses operand_b as its most significant select bit.
- R2: func_table = 4'b1000 makes result the bitwise AND of operand_a and operand_b.
- R3: func_table = 4'b1110 makes result the bitwise OR of the two operands.
- R4: func_table = 4'b0110 makes result the bitwise XOR of the two operands.
- R5: func_table = 4'b1010 makes result equal to operand_a, and operand_b has no effect.
- R6: func_table = 4'b0000 forces result to all zeros, and func_table = 4'b1111 forces it to all ones, whatever the operands are.
- R7: Each result bit depends only on the operand bits at its own position. Flipping one operand bit can change at most the result bit at that same position.
- R8: The result is combinational. It reflects the present inputs with no clock cycles of latency and holds no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_a | input | WIDTH (32) | First operand; low select bit of each slice |
| operand_b | input | WIDTH (32) | Second operand; high select bit of each slice |
| func_table | input | 4 | Truth table of the function; bit k is the output for select index k |
| result | output | WIDTH (32) | Bitwise function result |

## Verification
The block holds no state, so a fault lies in how a slice is wired or how its index is formed. Such a fault shows at the result port in the same cycle that the inputs are applied. It affects only the operand patterns that reach the faulty table entry. For that reason, every named function is driven with all-zero operands, all-one operands and mixed patterns, so that all four select indices are reached. Swapping the select bits or dropping a slice is exposed by functions that are not symmetric in their operands: pass-through of A and the single-operand inversions. Crosstalk between positions is exposed by single-bit flip tests.

// File: rtl/blu_pkg.sv
package blu_pkg;

  // Each slice selects with two operand bits.
  localparam int unsigned SEL_W = 2;
  // A truth table holds one entry per select combination.
  localparam int unsigned TBL_W = 1 << SEL_W;

  typedef logic [TBL_W-1:0] table_t;

  // Truth tables for the functions the datapath uses (index = {b,a}).
  localparam table_t TBL_AND   = 4'b1000;
  localparam table_t TBL_OR    = 4'b1110;
  localparam table_t TBL_XOR   = 4'b0110;
  localparam table_t TBL_PASSA = 4'b1010;
  localparam table_t TBL_ZERO  = 4'b0000;
  localparam table_t TBL_ONES  = 4'b1111;

endpackage

// File: rtl/blu_mux4.sv
module blu_mux4
  import blu_pkg::*;
(
  input  table_t           tbl,
  input  logic [SEL_W-1:0] sel,
  output logic             y
);

  always_comb begin
    unique case (sel)
      2'd0:    y = tbl[0];
      2'd1:    y = tbl[1];
      2'd2:    y = tbl[2];
      default: y = tbl[3];
    endcase
  end

endmodule

// File: rtl/blu_slice_array.sv
module blu_slice_array
  import blu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  table_t           tbl,
  output logic [WIDTH-1:0] y
);

  // One copy of the truth table per slice.
  table_t tbl_rep [WIDTH];

  for (genvar gi = 0; gi < WIDTH; gi++) begin : g_slice
    assign tbl_rep[gi] = tbl;

    blu_mux4 u_mux (
      .tbl (tbl_rep[gi]),
      .sel ({b[gi], a[gi]}),
      .y   (y[gi])
    );
  end

endmodule

// File: rtl/bitwise_logic_unit.sv
module bitwise_logic_unit
  import blu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] operand_a,
  input  logic [WIDTH-1:0] operand_b,
  input  logic [3:0]       func_table,
  output logic [WIDTH-1:0] result
);

  blu_slice_array #(
    .WIDTH (WIDTH)
  ) u_slices (
    .a   (operand_a),
    .b   (operand_b),
    .tbl (func_table),
    .y   (result)
  );

endmodule

// File: rtl/blu_checker.sv
module blu_checker
  import blu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input logic [WIDTH-1:0] operand_a,
  input logic [WIDTH-1:0] operand_b,
  input logic [3:0]       func_table,
  input logic [WIDTH-1:0] result
);

  logic known;
  assign known = !$isunknown({operand_a, operand_b, func_table});

  always_comb begin
    if (known && func_table == TBL_AND)
      AST_AND_FUNC: assert (result == (operand_a & operand_b)); // R2
    if (known && func_table == TBL_OR)
      AST_OR_FUNC: assert (result == (operand_a | operand_b)); // R3
    if (known && func_table == TBL_XOR)
      AST_XOR_FUNC: assert (result == (operand_a ^ operand_b)); // R4
    if (known && func_table == TBL_PASSA)
      AST_PASS_A: assert (result == operand_a); // R5
    if (known && func_table == TBL_ZERO)
      AST_CONST_ZERO: assert (result == '0); // R6
    if (known && func_table == TBL_ONES)
      AST_CONST_ONES: assert (result == '1); // R6
  end

endmodule

bind bitwise_logic_unit blu_checker #(
  .WIDTH (WIDTH)
) u_blu_checker (
  .operand_a  (operand_a),
  .operand_b  (operand_b),
  .func_table (func_table),
  .result     (result)
);

// File: tb/tb_bitwise_logic_unit.sv
`timescale 1ns/1ps
module tb_bitwise_logic_unit;

  localparam int W = 32;
  localparam int NV = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [W-1:0] a, b, y;
  logic [3:0]   f;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  bitwise_logic_unit #(.WIDTH(W)) dut (
    .operand_a  (a),
    .operand_b  (b),
    .func_table (f),
    .result     (y)
  );

  // Stimulus table: operand A, operand B, truth table.
  localparam logic [W-1:0] VA [NV] = '{
    32'h0000_0000, 32'hFFFF_FFFF, 32'h3C5A_9F01,
    32'h0000_0000, 32'hFFFF_FFFF, 32'hA5F0_0C37,
    32'h0000_0000, 32'hFFFF_FFFF, 32'h1234_ABCD,
    32'h0000_0000, 32'hFFFF_FFFF, 32'hDEAD_BEEF,
    32'h6B1F_00E4, 32'h6B1F_00E4, 32'h6B1F_00E4, 32'h6B1F_00E4};
  localparam logic [W-1:0] VB [NV] = '{
    32'h0000_0000, 32'hFFFF_FFFF, 32'h96C3_5AF0,
    32'h0000_0000, 32'hFFFF_FFFF, 32'h0FF0_7B81,
    32'h0000_0000, 32'hFFFF_FFFF, 32'hF0F0_5555,
    32'hFFFF_FFFF, 32'h0000_0000, 32'h7777_0001,
    32'hC30A_5F96, 32'hC30A_5F96, 32'hC30A_5F96, 32'hC30A_5F96};
  localparam logic [3:0] VF [NV] = '{
    4'b1000, 4'b1000, 4'b1000,
    4'b1110, 4'b1110, 4'b1110,
    4'b0110, 4'b0110, 4'b0110,
    4'b1010, 4'b1010, 4'b1010,
    4'b0001, 4'b0111, 4'b0101, 4'b1100};

  // Behavioural model of the requirements.
  function automatic logic [W-1:0] model(input logic [W-1:0] ma, input logic [W-1:0] mb,
                                         input logic [3:0] mf);
    logic [W-1:0] r;
    case (mf)
      4'b1000: r = ma & mb;        // R2
      4'b1110: r = ma | mb;        // R3
      4'b0110: r = ma ^ mb;        // R4
      4'b1010: r = ma;             // R5
      4'b0000: r = '0;             // R6
      4'b1111: r = '1;             // R6
      4'b0001: r = ~(ma | mb);
      4'b0111: r = ~(ma & mb);
      4'b0101: r = ~ma;
      4'b1100: r = mb;
      default: for (int i = 0; i < W; i++) r[i] = mf[{mb[i], ma[i]}]; // R1
    endcase
    return r;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] ta, input logic [W-1:0] tb_, input logic [3:0] tf);
    @(negedge clk);
    a = ta; b = tb_; f = tf;
    #1;
  endtask

  function automatic string tag_of(input logic [3:0] tf);
    case (tf)
      4'b1000: return "R2";
      4'b1110: return "R3";
      4'b0110: return "R4";
      4'b1010: return "R5";
      default: return "R1";
    endcase
  endfunction

  initial begin
    a = '0; b = '0; f = 4'b1000;
    #1;
    // R8: output valid at start with no clock edge seen
    check("R8 start", y, 32'h0);

    for (int v = 0; v < NV; v++) begin
      apply(VA[v], VB[v], VF[v]);
      check(tag_of(VF[v]), y, model(VA[v], VB[v], VF[v]));
    end

    // R1: every one of the 16 tables on mixed operands
    for (int t = 0; t < 16; t++) begin
      apply(32'h0F0F_3355, 32'h00FF_0F0F, t[3:0]);
      check("R1 table", y, model(32'h0F0F_3355, 32'h00FF_0F0F, t[3:0]));
    end

    // R5: operand_b has no effect on pass-through
    apply(32'h8421_1248, 32'h0000_0000, 4'b1010);
    check("R5 b=0", y, 32'h8421_1248);
    apply(32'h8421_1248, 32'hFFFF_FFFF, 4'b1010);
    check("R5 b=1s", y, 32'h8421_1248);

    // R6: constant tables ignore operands
    apply(32'hFFFF_FFFF, 32'h5A5A_A5A5, 4'b0000);
    check("R6 zero", y, 32'h0000_0000);
    apply(32'h0000_0000, 32'h5A5A_A5A5, 4'b1111);
    check("R6 ones", y, 32'hFFFF_FFFF);

    // R7: single bit flip touches only its own position
    apply(32'h0000_0000, 32'h0000_0000, 4'b0110);
    check("R7 base", y, 32'h0);
    apply(32'h0002_0000, 32'h0000_0000, 4'b0110);
    check("R7 flip a17", y, 32'h0002_0000);
    apply(32'h0000_0000, 32'h8000_0000, 4'b0110);
    check("R7 flip b31", y, 32'h8000_0000);
    apply(32'h0000_0001, 32'h0000_0000, 4'b0110);
    check("R7 flip a0", y, 32'h0000_0001);

    // R8: result follows inputs with no added latency
    a = 32'hCAFE_0000; b = 32'h0000_F00D; f = 4'b1110;
    #1;
    check("R8 same-time", y, 32'hCAFE_F00D);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule